// File: doc/BRIEF.md
# Receive Timing Marker Generator for an E1/T1 Framer

This block tracks the bit, time-slot, frame and multiframe position on the system side of an E1 or T1 receive framer and turns that position into three one-bit timing markers for the downstream receive data path. A free-running position counter advances one bit per system clock. An external frame synchronization pulse, together with a programmable bit offset, re-aligns the counter so that time slot 0 of multiframe frame 0 lands where the system expects it. The sync pulse may arrive every frame or every few frames. A pulse that arrives while the counter is already aligned changes nothing.

The three markers are as follows. A frame marker pulses at a programmable bit position in every frame, and it can be launched on the rising or the falling clock edge. A multiframe-begin marker follows the E1 or T1 multiframe rules. A signaling marker either flags the time slots selected by a 32-bit mask or, in T1 robbed-bit mode, flags the least significant bit of every channel in every sixth frame. Each marker is registered. The registered value reflects the position of the same clock cycle in which it is visible.

Top module: `rx_marker_gen`

## Requirements
- R1: While `rst_ni` is low, all three outputs are 0. After release, the internal reset is removed on the second rising edge. From that point the counter free-runs from bit position 0 of frame 0 with no sync pulse, so position p is current in the cycle after rising edge p+2.
- R2: If `sync_i` is high in cycle k, cycle k counts as position (L - (O mod L)) mod L. L is the frame length and O is `ofs_i`, which must be below 2L. Position 0 of frame 0 of the multiframe then follows O cycles later. With O mod L = 0, cycle k itself is position 0 of frame 0.
- R3: An E1 frame is 256 bit positions: 32 slots of 8 bits, with slot n at positions 8n..8n+7. A T1 frame is 193 positions: a framing bit at position 0, then 24 slots of 8 bits, with slot n at positions 8n+1..8n+8. The counter wraps from L-1 to 0 and then moves to the next frame.
- R4: `frame_mark_o` is high for exactly the one cycle whose position equals `fm_pos_i`, once per frame. It never fires if `fm_pos_i` is L or more.
- R5: With `fm_negedge_i`=1, the frame marker is relaunched on the falling clock edge and lags the rising-edge version by half a cycle. With `fm_negedge_i`=0, it changes on the rising edge.
- R6: In E1 mode (`t1_mode_i`=0) the multiframe is 16 frames. `mf_begin_o` is high for one cycle at position 0 of frame 0. With `e1_cas_mf_i`=1 it moves to position 128 (the start of slot 16) of frame 0.
- R7: In T1 mode the multiframe is 12 frames (`t1_ext_i`=0) or 24 frames (`t1_ext_i`=1). With `t1_mf_all_i`=1, `mf_begin_o` pulses at position 0 of frame 0 only. With `t1_mf_all_i`=0, it pulses at position 0 of frames 0 and 12.
- R8: Unless T1 robbed-bit mode is active, `sig_mark_o` is high on every position of slot n when bit n of `slot_mask_i` is 1. In T1 mode, mask bits 24..31 are ignored and the framing bit is never marked.
- R9: In T1 mode with `rbs_en_i`=1, `sig_mark_o` ignores the mask and is high only on the last bit of each slot (position 8n+8) in frames 5, 11, 17 and 23 (every sixth frame, counted from frame 0). In E1 mode, `rbs_en_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Frame synchronization pulse |
| t1_mode_i | input | 1 | 1 = T1 (193-bit frames), 0 = E1 (256-bit frames) |
| t1_ext_i | input | 1 | T1 multiframe length: 1 = 24 frames, 0 = 12 frames |
| t1_mf_all_i | input | 1 | T1 begin marker: 1 = multiframe start only, 0 = every 12 frames |
| e1_cas_mf_i | input | 1 | E1 begin marker at the start of slot 16 instead of slot 0 |
| rbs_en_i | input | 1 | T1 robbed-bit signaling marker enable |
| fm_negedge_i | input | 1 | Launch the frame marker on the falling clock edge |
| fm_pos_i | input | 9 | Bit position of the frame marker within the frame |
| ofs_i | input | 9 | Bit offset from the sync pulse to time slot 0 |
| slot_mask_i | input | 32 | Time-slot selection mask for the signaling marker |
| frame_mark_o | output | 1 | Frame marker |
| mf_begin_o | output | 1 | Multiframe / superframe begin marker |
| sig_mark_o | output | 1 | Signaling time-slot / robbed-bit marker |

## Verification
The bench targets the following corner cases:
- **Offset wrap.** An offset of the frame length or more must reduce modulo the frame length. A design that skipped the reduction would place every marker at the wrong position or underflow its start value.
- **Offset 0 versus offset 1.** These two values decide whether the sync cycle itself or the cycle after it begins frame 0. An off-by-one shifts all markers by a cycle and puts the multiframe in the wrong frame.
- **T1 slot layout.** The bench places the frame marker on the final T1 bit and also beyond the T1 frame, where a wrong frame length shows up as a missing or spurious pulse.
- **T1 mask and framing bit.** It applies a mask with only bits 24..31 set in T1, and checks that the framing bit is never flagged. A design that shifted T1 slots by one bit would mark the framing bit.
- **Extra pulse and robbed bit.** It checks the extra frame-12 begin pulse and the frame-5/11/17/23 robbed-bit pattern, where an off-by-one frame count is easy to make.
- **Launch edge.** Each frame marker is sampled both before and after the falling edge, which exposes a launch on the wrong edge.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

  localparam int unsigned POS_W      = 9;
  localparam int unsigned FRM_W      = 5;
  localparam int unsigned SLOT_BITS  = 8;
  localparam int unsigned BIT_W      = $clog2(SLOT_BITS);
  localparam int unsigned E1_SLOTS   = 32;
  localparam int unsigned T1_SLOTS   = 24;
  localparam int unsigned SLOT_W     = $clog2(E1_SLOTS);
  localparam int unsigned E1_FLEN    = E1_SLOTS * SLOT_BITS;
  localparam int unsigned T1_FLEN    = T1_SLOTS * SLOT_BITS + 1;
  localparam int unsigned E1_MFLEN   = 16;
  localparam int unsigned T1_SF_LEN  = 12;
  localparam int unsigned T1_ESF_LEN = 24;
  localparam int unsigned CAS_SLOT   = 16;
  localparam int unsigned RBS_EVERY  = 6;

  typedef struct packed {
    logic t1;
    logic ext;
    logic mf_all;
    logic cas_mf;
    logic rbs_en;
  } rxm_mode_t;

endpackage

// File: rtl/rxm_rst_sync.sv
module rxm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/rxm_pos_ctr.sv
module rxm_pos_ctr
  import rxm_pkg::*;
#(
  parameter int unsigned PW = POS_W,
  parameter int unsigned FW = FRM_W
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sync_i,
  input  rxm_mode_t mode_i,
  input  logic [PW-1:0] ofs_i,
  output logic [PW-1:0] pos_q,
  output logic [FW-1:0] frm_q,
  output logic [PW-1:0] pos_d,
  output logic [FW-1:0] frm_d
);

  logic [PW:0]   flen, ofs_m, start, pos_inc;
  logic [FW-1:0] mflen;
  logic [FW:0]   frm_inc;
  logic          adv_en;

  always_comb begin
    flen  = mode_i.t1 ? (PW+1)'(T1_FLEN) : (PW+1)'(E1_FLEN);
    mflen = !mode_i.t1 ? FW'(E1_MFLEN) : (mode_i.ext ? FW'(T1_ESF_LEN) : FW'(T1_SF_LEN));
    // offset reduced modulo frame length (valid for offsets below 2*L)
    ofs_m = ({1'b0, ofs_i} >= flen) ? {1'b0, ofs_i} - flen : {1'b0, ofs_i};
    start = flen - ofs_m + (PW+1)'(1);
    if (start >= flen) start = start - flen;
    pos_inc = {1'b0, pos_q} + (PW+1)'(1);
    frm_inc = {1'b0, frm_q} + (FW+1)'(1);
    adv_en  = 1'b1;
    pos_d   = pos_q;
    frm_d   = frm_q;
    if (sync_i) begin
      pos_d = start[PW-1:0];
      frm_d = (ofs_m == '0 || start == '0) ? '0 : mflen - FW'(1);
    end else if (adv_en) begin
      if (pos_inc >= flen) begin
        pos_d = '0;
        frm_d = (frm_inc >= {1'b0, mflen}) ? '0 : frm_inc[FW-1:0];
      end else begin
        pos_d = pos_inc[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      frm_q <= '0;
    end else begin
      pos_q <= pos_d;
      frm_q <= frm_d;
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) (!sync_i && {1'b0, pos_q} == flen - (PW+1)'(1)) |=> (pos_q == '0)) else $error("frame wrap"); // R3
  AST_BIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) (!sync_i && pos_inc < flen) |=> (pos_q == $past(pos_q) + PW'(1))) else $error("bit step"); // R3
  AST_SYNC_OFS1: assert property (@(posedge clk_i) disable iff (!rst_ni) (sync_i && ofs_i == PW'(1)) |=> (pos_q == '0 && frm_q == '0)) else $error("sync align"); // R2

endmodule

// File: rtl/rxm_mark_dec.sv
module rxm_mark_dec
  import rxm_pkg::*;
#(
  parameter int unsigned PW    = POS_W,
  parameter int unsigned FW    = FRM_W,
  parameter int unsigned NSLOT = E1_SLOTS
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sync_i,
  input  rxm_mode_t mode_i,
  input  logic [PW-1:0]    fm_pos_i,
  input  logic [NSLOT-1:0] mask_i,
  input  logic [PW-1:0]    pos_d,
  input  logic [FW-1:0]    frm_d,
  input  logic [PW-1:0]    pos_q,
  input  logic [FW-1:0]    frm_q,
  output logic             fm_q,
  output logic             mf_q,
  output logic             sig_q
);

  localparam logic [PW-1:0] CAS_POS = PW'(CAS_SLOT * SLOT_BITS);

  logic [NSLOT-1:0]  mask_ok;
  logic [PW-1:0]     k;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bitn;
  logic in_slot, rbs_frm, fm_d, mf_d, sig_d;

  // slots beyond the T1 count are disabled in T1 mode
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g < T1_SLOTS) begin : g_both
      assign mask_ok[g] = mask_i[g];
    end else begin : g_e1_only
      assign mask_ok[g] = mask_i[g] & ~mode_i.t1;
    end
  end

  always_comb begin
    in_slot = !(mode_i.t1 && pos_d == '0);
    k       = mode_i.t1 ? pos_d - PW'(1) : pos_d;
    slot    = SLOT_W'(k >> BIT_W);
    bitn    = k[BIT_W-1:0];
    rbs_frm = (FW'(frm_d % FW'(RBS_EVERY)) == FW'(RBS_EVERY - 1));
    fm_d    = (pos_d == fm_pos_i);
    if (mode_i.t1)
      mf_d = (pos_d == '0) && (frm_d == '0 || (!mode_i.mf_all && frm_d == FW'(T1_SF_LEN)));
    else
      mf_d = (frm_d == '0) && (pos_d == (mode_i.cas_mf ? CAS_POS : '0));
    if (mode_i.t1 && mode_i.rbs_en)
      sig_d = in_slot && (bitn == BIT_W'(SLOT_BITS - 1)) && rbs_frm;
    else
      sig_d = in_slot && mask_ok[slot];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fm_q  <= 1'b0;
      mf_q  <= 1'b0;
      sig_q <= 1'b0;
    end else begin
      fm_q  <= fm_d;
      mf_q  <= mf_d;
      sig_q <= sig_d;
    end
  end

  AST_FM_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (fm_q && !sync_i && $stable(fm_pos_i)) |=> !fm_q) else $error("frame marker width"); // R4
  AST_SIG_FRAMING: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(mode_i.t1) && pos_q == '0) |-> !sig_q) else $error("framing bit marked"); // R8
  AST_RBS_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(mode_i.t1 && mode_i.rbs_en) && sig_q) |-> (pos_q[BIT_W-1:0] == '0 && pos_q != '0)) else $error("robbed bit position"); // R9
  AST_E1_MF_START: assert property (@(posedge clk_i) disable iff (!rst_ni) ($past(!mode_i.t1 && !mode_i.cas_mf) && mf_q) |-> (pos_q == '0 && frm_q == '0)) else $error("E1 begin position"); // R6

endmodule

// File: rtl/rxm_edge_launch.sv
module rxm_edge_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic neg_sel_i,
  input  logic mark_i,
  output logic mark_o
);

  logic neg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= mark_i;
  end

  assign mark_o = neg_sel_i ? neg_q : mark_i;

  AST_NEG_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni) neg_q == mark_i) else $error("falling-edge copy lost"); // R5

endmodule

// File: rtl/rx_marker_gen.sv
module rx_marker_gen
  import rxm_pkg::*;
#(
  parameter int unsigned PW    = POS_W,
  parameter int unsigned FW    = FRM_W,
  parameter int unsigned NSLOT = E1_SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             t1_mode_i,
  input  logic             t1_ext_i,
  input  logic             t1_mf_all_i,
  input  logic             e1_cas_mf_i,
  input  logic             rbs_en_i,
  input  logic             fm_negedge_i,
  input  logic [PW-1:0]    fm_pos_i,
  input  logic [PW-1:0]    ofs_i,
  input  logic [NSLOT-1:0] slot_mask_i,
  output logic             frame_mark_o,
  output logic             mf_begin_o,
  output logic             sig_mark_o
);

  rxm_mode_t     mode;
  logic          rst_n_int;
  logic [PW-1:0] pos_q, pos_d;
  logic [FW-1:0] frm_q, frm_d;
  logic          fm_r;

  assign mode = '{t1: t1_mode_i, ext: t1_ext_i, mf_all: t1_mf_all_i,
                  cas_mf: e1_cas_mf_i, rbs_en: rbs_en_i};

  rxm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n_int)
  );

  rxm_pos_ctr #(.PW(PW), .FW(FW)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_n_int), .sync_i(sync_i), .mode_i(mode),
    .ofs_i(ofs_i), .pos_q(pos_q), .frm_q(frm_q), .pos_d(pos_d), .frm_d(frm_d)
  );

  rxm_mark_dec #(.PW(PW), .FW(FW), .NSLOT(NSLOT)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_n_int), .sync_i(sync_i), .mode_i(mode),
    .fm_pos_i(fm_pos_i), .mask_i(slot_mask_i), .pos_d(pos_d), .frm_d(frm_d),
    .pos_q(pos_q), .frm_q(frm_q), .fm_q(fm_r), .mf_q(mf_begin_o), .sig_q(sig_mark_o)
  );

  rxm_edge_launch u_fm_edge (
    .clk_i(clk_i), .rst_ni(rst_n_int), .neg_sel_i(fm_negedge_i),
    .mark_i(fm_r), .mark_o(frame_mark_o)
  );

endmodule

// File: tb/rx_marker_gen_bench.sv
module rx_marker_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0;
  logic t1 = 1'b0, ext = 1'b0, mf_all = 1'b0, cas = 1'b0, rbs = 1'b0, fneg = 1'b0;
  logic [8:0]  fm_pos = '0;
  logic [8:0]  ofs = '0;
  logic [31:0] mask = '0;
  logic fm_o, mf_o, sg_o;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  bit fm_e [MAXN];
  bit fm_l [MAXN];
  bit mf_a [MAXN];
  bit sg_a [MAXN];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_marker_gen u_rx_marker_gen (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .t1_mode_i(t1), .t1_ext_i(ext),
    .t1_mf_all_i(mf_all), .e1_cas_mf_i(cas), .rbs_en_i(rbs), .fm_negedge_i(fneg),
    .fm_pos_i(fm_pos), .ofs_i(ofs), .slot_mask_i(mask),
    .frame_mark_o(fm_o), .mf_begin_o(mf_o), .sig_mark_o(sg_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected markers for cycle i after the sync cycle (cycle 0), from the requirements
  function automatic void model(input int i, output bit efm, output bit emf, output bit esg);
    int flen, mfl, om, a, pos, frm, k, slot, bitn;
    bit inslot;
    flen = t1 ? 193 : 256;
    mfl  = t1 ? (ext ? 24 : 12) : 16;
    om   = int'(ofs) % flen;
    a    = i - om;
    if (a < 0) begin pos = a + flen; frm = mfl - 1; end
    else begin pos = a % flen; frm = (a / flen) % mfl; end
    efm = (pos == int'(fm_pos));
    if (t1) emf = (pos == 0) && (frm == 0 || (!mf_all && frm == 12));
    else    emf = (frm == 0) && (pos == (cas ? 128 : 0));
    inslot = !(t1 && pos == 0);
    k = t1 ? pos - 1 : pos;
    slot = (k < 0) ? 0 : k / 8;
    bitn = (k < 0) ? 0 : k % 8;
    if (t1 && rbs) esg = inslot && bitn == 7 && (frm % 6 == 5);
    else           esg = inslot && mask[slot] && (!t1 || slot < 24);
  endfunction

  task automatic sync_capture(input int n);
    @(posedge clk); #1 sync = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); #1;
      sync = 1'b0;
      fm_e[i] = fm_o; mf_a[i] = mf_o; sg_a[i] = sg_o;
      #6 fm_l[i] = fm_o;
    end
  endtask

  task automatic compare(input string name, input int n, input string rmf, input string rsg);
    bit efm, emf, esg, pfm, d1, d2;
    int bad_l = -1, bad_e = -1, bad_m = -1, bad_s = -1;
    for (int i = 1; i <= n; i++) begin
      model(i, efm, emf, esg);
      if (fm_l[i] != efm && bad_l < 0) bad_l = i;
      if (mf_a[i] != emf && bad_m < 0) bad_m = i;
      if (sg_a[i] != esg && bad_s < 0) bad_s = i;
      if (i >= 2) begin
        model(i - 1, pfm, d1, d2);
        if (fm_e[i] != (fneg ? pfm : efm) && bad_e < 0) bad_e = i;
      end
    end
    check(bad_l < 0, "R4", $sformatf("%s frame marker first bad cycle", name), bad_l, -1);
    check(bad_e < 0, "R5", $sformatf("%s frame marker launch edge first bad cycle", name), bad_e, -1);
    check(bad_m < 0, rmf, $sformatf("%s begin marker first bad cycle", name), bad_m, -1);
    check(bad_s < 0, rsg, $sformatf("%s signaling marker first bad cycle", name), bad_s, -1);
  endtask

  task automatic cfg(input logic a_t1, a_ext, a_all, a_cas, a_rbs, a_neg,
                     input int a_fm, a_ofs, input logic [31:0] a_mask);
    @(posedge clk); #1;
    t1 = a_t1; ext = a_ext; mf_all = a_all; cas = a_cas; rbs = a_rbs; fneg = a_neg;
    fm_pos = 9'(a_fm); ofs = 9'(a_ofs); mask = a_mask;
  endtask

  // R1: reset holds outputs low, then free-run from position 0
  task automatic test_reset;
    cfg(0, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF);
    repeat (3) @(posedge clk);
    #1 check(fm_o == 0, "R1", "frame marker in reset", fm_o, 0);
    check(mf_o == 0, "R1", "begin marker in reset", mf_o, 0);
    check(sg_o == 0, "R1", "signaling marker in reset", sg_o, 0);
    fm_pos = 9'd5; mask = '0;
    @(posedge clk); #1 rst_n = 1'b1;
    for (int e = 1; e <= 4098; e++) begin
      @(posedge clk); #1;
      if (e == 6)    check(fm_o == 0, "R1", "frame marker before pos 5", fm_o, 0);
      if (e == 7)    check(fm_o == 1, "R1", "frame marker at pos 5 of first frame", fm_o, 1);
      if (e == 263)  check(fm_o == 1, "R3", "frame marker one E1 frame later", fm_o, 1);
      if (e == 4097) check(mf_o == 0, "R1", "begin marker before free-run multiframe", mf_o, 0);
      if (e == 4098) check(mf_o == 1, "R6", "begin marker after 16 free-run frames", mf_o, 1);
    end
  endtask

  task automatic test_e1_basic;  // R2 R3 R4 R6 R8
    cfg(0, 0, 0, 0, 0, 0, 5, 0, 32'h8001_0003);
    sync_capture(4136);
    compare("e1 ofs0", 4136, "R6", "R8");
  endtask

  task automatic test_e1_cas;  // R6 cas option, R9 ignored in E1
    cfg(0, 0, 0, 1, 1, 0, 200, 100, 32'h4000_8010);
    sync_capture(4136);
    compare("e1 cas ofs100", 4136, "R6", "R9");
  endtask

  task automatic test_e1_wrap_neg;  // R2 offset >= L, R5 falling edge
    cfg(0, 0, 0, 0, 0, 1, 255, 300, 32'hFFFF_FFFF);
    sync_capture(600);
    compare("e1 ofs300 negedge", 600, "R6", "R8");
  endtask

  task automatic test_t1_sf;  // R3 R7 R8
    cfg(1, 0, 1, 0, 0, 0, 0, 190, 32'h00FF_0F0F);
    sync_capture(2346);
    compare("t1 sf ofs190", 2346, "R7", "R8");
  endtask

  task automatic test_t1_esf_rbs;  // R7 frame-12 pulse, R9 robbed bit
    cfg(1, 1, 0, 0, 1, 0, 192, 250, 32'h0000_0000);
    sync_capture(4662);
    compare("t1 esf rbs ofs250", 4662, "R7", "R9");
  endtask

  task automatic test_t1_ignored;  // R4 beyond frame, R8 upper mask bits
    int nfm = 0, nsg = 0;
    cfg(1, 1, 1, 0, 0, 1, 200, 0, 32'hFF00_0000);
    sync_capture(4662);
    compare("t1 esf ofs0 negedge", 4662, "R7", "R8");
    for (int i = 1; i <= 4662; i++) begin
      nfm += int'(fm_l[i]);
      nsg += int'(sg_a[i]);
    end
    check(nfm == 0, "R4", "frame marker pulses for position beyond T1 frame", nfm, 0);
    check(nsg == 0, "R8", "signaling pulses from T1 mask bits 24..31", nsg, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errs++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_e1_basic();
    test_e1_cas();
    test_e1_wrap_neg();
    test_t1_sf();
    test_t1_esf_rbs();
    test_t1_ignored();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule